// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Scheduler

This block keeps an EDO DRAM bank alive. Out of reset it waits for the power-up pause, then runs a burst of CAS-before-RAS cycles that prime the internal refresh counter. Only after that burst does it raise `ready`. From then on an interval timer marks when each refresh falls due. Every mark adds one to a backlog of owed refreshes, and every refresh that completes takes one away.

The scheduler shares the strobes with an access controller through a request/grant pair. It raises `rfsh_req` whenever a cycle is owed and holds it until the cycle ends. It starts driving only on a clock edge where it sees `rfsh_grant` high. It then owns the strobes (`bus_own` high) for the whole sequence:
- a lead with both strobes high;
- CAS low while RAS stays high;
- RAS low;
- a precharge with both strobes high.

After that it drops ownership and pulses `rfsh_done` for one cycle, with `rfsh_req` low. Once a sequence has started, withdrawing the grant has no effect until the done pulse. While it does not own the bus, all strobes rest high. WE is never driven low, so no cycle can be taken as a write.

All timing parameters are given in nanoseconds. They are turned into whole clock cycles by rounding up, with a minimum of one cycle. The CAS setup phase is long enough for both the CAS-before-RAS setup and the WE setup. The RAS-low phase is long enough for both the minimum RAS pulse and the CAS hold after RAS falls.

Top module: `dram_rfsh_sched`

## Requirements
- R1: While reset is asserted, `ras_n`, `cas_n` and `we_n` are 1, and `rfsh_req`, `bus_own`, `rfsh_done`, `ready`, `urgent` and `owed_cnt` are all 0.
- R2: No request and no bus ownership occur until ceil(PAUSE_NS/clock period) cycles after reset release. The first request follows within a few cycles of that point.
- R3: Exactly INIT_CYCLES refresh sequences complete before `ready` rises. Once high, `ready` stays high until reset.
- R4: In each sequence RAS is high with CAS high for at least ceil(RAS_PRE_CAS_NS) cycles after ownership begins. CAS then falls and stays low for ceil(max(CAS_SETUP_NS, WE_SETUP_NS)) cycles before RAS falls.
- R5: CAS is low during every cycle in which RAS is low. It rises in the same cycle as RAS.
- R6: RAS stays low for ceil(max(RAS_LOW_NS, CAS_HOLD_NS)) cycles. Both strobes are then high for ceil(RAS_PRECHARGE_NS) cycles before the done pulse.
- R7: `we_n` is 1 at all times.
- R8: `bus_own` rises only after a cycle in which both `rfsh_req` and `rfsh_grant` were high. RAS or CAS is low only while `bus_own` is high. Without a grant, `rfsh_req` stays high and the strobes stay idle.
- R9: Deasserting `rfsh_grant` in the middle of a sequence neither shortens nor aborts it.
- R10: After `ready`, `owed_cnt` increases by one every ceil(INTERVAL_NS) cycles. It decreases by one for each completed refresh, and a tick and a completion in the same cycle cancel.
- R11: `owed_cnt` saturates at MAX_OWED, and further ticks are dropped.
- R12: `urgent` is 1 exactly when `owed_cnt` >= URGENT_AT.
- R13: `rfsh_done` is a single-cycle pulse. `bus_own` and `rfsh_req` are low during it, and it directly follows the precharge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rfsh_grant | input | 1 | Access controller hands the strobes over |
| rfsh_req | output | 1 | A refresh or init cycle is wanted or in progress |
| bus_own | output | 1 | Scheduler is driving the strobes |
| rfsh_done | output | 1 | One-cycle pulse: sequence finished, bus released |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| ready | output | 1 | Startup pause and init burst both complete |
| urgent | output | 1 | Backlog has reached URGENT_AT |
| owed_cnt | output | OWED_W | Refreshes owed but not yet done |

## Verification
The backlog logic is tried with the grant withheld for windows of 1, 3, 6, 7, 8 and 11 interval periods, each followed by a drain with the grant restored. These windows separate an exact per-tick count, the urgent threshold on both sides, and saturation at the cap. The strobe shape is measured on the init burst and on later refreshes. A directed run pulls the grant away while RAS is low, which separates a sequence that completes from one that obeys the grant mid-cycle. A reset check and a pause-length measurement show that nothing starts early.

// File: rtl/rfsh_sched_pkg.sv
`timescale 1ns/1ps
package rfsh_sched_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_REQ,
    ST_LEAD,
    ST_CSR,
    ST_RASL,
    ST_PRE,
    ST_DONE
  } rfsh_state_e;

  // Round a duration in ns up to whole clock cycles, never below one.
  function automatic int ns_to_cycles(input int ns, input int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfsh_cycle_timer.sv
`timescale 1ns/1ps
module rfsh_cycle_timer #(
  parameter int CYCLES   = 4,
  parameter bit ONE_SHOT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic hit
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  generate
    if (ONE_SHOT) begin : g_once
      localparam logic [CW-1:0] TERM = CW'(CYCLES);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (en && cnt_q != TERM) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      assign hit = (cnt_q == TERM);

      // R2: once the pause has run out it never restarts
      a_r2_pause_latched: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> hit);
    end else begin : g_period
      localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (en) begin
          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
      end

      assign hit = en && (cnt_q == LAST);

      if (CYCLES > 1) begin : g_chk
        // R10: ticks are never back to back
        a_r10_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
          hit |=> !hit);
      end
    end
  endgenerate

endmodule

// File: rtl/rfsh_owed_counter.sv
`timescale 1ns/1ps
module rfsh_owed_counter #(
  parameter int MAX_OWED  = 8,
  parameter int URGENT_AT = 6,
  parameter int W         = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] owed,
  output logic         urgent
);

  localparam logic [W-1:0] CAP = W'(MAX_OWED);
  localparam logic [W-1:0] URG = W'(URGENT_AT);

  logic [W-1:0] owed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_q <= '0;
    end else begin
      unique case ({inc, dec})
        2'b10:   if (owed_q != CAP) owed_q <= owed_q + 1'b1;
        2'b01:   if (owed_q != '0)  owed_q <= owed_q - 1'b1;
        default: owed_q <= owed_q;
      endcase
    end
  end

  assign owed   = owed_q;
  assign urgent = (owed_q >= URG);

  // R11: backlog never exceeds its cap
  a_r11_never_above_cap: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q <= CAP);

  // R11: a lone tick at the cap is dropped
  a_r11_hold_at_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_q == CAP && inc && !dec) |=> owed_q == CAP);

  // R10: the backlog moves by at most one per cycle
  a_r10_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_q != $past(owed_q)) |->
      ((owed_q - $past(owed_q)) == W'(1) || ($past(owed_q) - owed_q) == W'(1)));

endmodule

// File: rtl/rfsh_cbr_seq.sv
`timescale 1ns/1ps
module rfsh_cbr_seq
  import rfsh_sched_pkg::*;
#(
  parameter int LEAD_CYC = 1,
  parameter int CSR_CYC  = 3,
  parameter int RASL_CYC = 10,
  parameter int PRE_CYC  = 6,
  parameter int INIT_CNT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pause_done,
  input  logic owed_pending,
  input  logic gnt,
  output logic req,
  output logic own,
  output logic done,
  output logic ras_n,
  output logic cas_n,
  output logic ready,
  output logic refresh_cmp
);

  localparam int PH_MAX = max2(max2(LEAD_CYC, CSR_CYC), max2(RASL_CYC, PRE_CYC));
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int IW     = $clog2(INIT_CNT + 1);

  rfsh_state_e   state_q, nxt;
  logic [PH_W-1:0] ph_q;
  logic [IW-1:0]   init_left_q;
  logic            ph_last;
  logic            timed;

  always_comb begin
    unique case (state_q)
      ST_LEAD: ph_last = (ph_q == PH_W'(LEAD_CYC - 1));
      ST_CSR:  ph_last = (ph_q == PH_W'(CSR_CYC - 1));
      ST_RASL: ph_last = (ph_q == PH_W'(RASL_CYC - 1));
      ST_PRE:  ph_last = (ph_q == PH_W'(PRE_CYC - 1));
      default: ph_last = 1'b1;
    endcase
  end

  assign timed = (state_q == ST_LEAD) || (state_q == ST_CSR) ||
                 (state_q == ST_RASL) || (state_q == ST_PRE);

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_PAUSE: if (pause_done) nxt = ST_IDLE;
      ST_IDLE:  if (init_left_q != '0 || owed_pending) nxt = ST_REQ;
      ST_REQ:   if (gnt) nxt = ST_LEAD;
      ST_LEAD:  if (ph_last) nxt = ST_CSR;
      ST_CSR:   if (ph_last) nxt = ST_RASL;
      ST_RASL:  if (ph_last) nxt = ST_PRE;
      ST_PRE:   if (ph_last) nxt = ST_DONE;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_PAUSE;
      ph_q        <= '0;
      init_left_q <= IW'(INIT_CNT);
    end else begin
      state_q <= nxt;
      if (nxt != state_q) begin
        ph_q <= '0;
      end else if (timed) begin
        ph_q <= ph_q + 1'b1;
      end
      if (state_q == ST_DONE && init_left_q != '0) begin
        init_left_q <= init_left_q - 1'b1;
      end
    end
  end

  assign own   = timed;
  assign req   = (state_q == ST_REQ) || timed;
  assign done  = (state_q == ST_DONE);
  assign ras_n = (state_q != ST_RASL);
  assign cas_n = !((state_q == ST_CSR) || (state_q == ST_RASL));
  assign ready = (init_left_q == '0);
  assign refresh_cmp = done && ready;

  // R4: RAS only falls after CAS has already been low
  a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> !$past(cas_n));

  // R4: CAS falls while RAS is still high
  a_r4_ras_high_at_cas_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> ras_n);

  // R5: CAS is released together with RAS
  a_r5_cas_rises_with_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> $rose(ras_n));

  // R8: ownership begins only after a granted request
  a_r8_own_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own) |-> ($past(gnt) && $past(req)));

  // R13: done follows a precharge cycle and lasts one cycle
  a_r13_done_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(own) && $past(ras_n) && $past(cas_n)));

  a_r13_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/dram_rfsh_sched.sv
`timescale 1ns/1ps
module dram_rfsh_sched #(
  parameter  int CLK_PS           = 5000,
  parameter  int PAUSE_NS         = 100000,
  parameter  int INTERVAL_NS      = 15600,
  parameter  int INIT_CYCLES      = 8,
  parameter  int RAS_PRE_CAS_NS   = 5,
  parameter  int CAS_SETUP_NS     = 12,
  parameter  int WE_SETUP_NS      = 12,
  parameter  int CAS_HOLD_NS      = 8,
  parameter  int RAS_LOW_NS       = 50,
  parameter  int RAS_PRECHARGE_NS = 30,
  parameter  int MAX_OWED         = 8,
  parameter  int URGENT_AT        = 6,
  localparam int OWED_W           = $clog2(MAX_OWED + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rfsh_grant,
  output logic              rfsh_req,
  output logic              bus_own,
  output logic              rfsh_done,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              ready,
  output logic              urgent,
  output logic [OWED_W-1:0] owed_cnt
);

  import rfsh_sched_pkg::*;

  localparam int PAUSE_CYC    = ns_to_cycles(PAUSE_NS, CLK_PS);
  localparam int INTERVAL_CYC = ns_to_cycles(INTERVAL_NS, CLK_PS);
  localparam int LEAD_CYC     = ns_to_cycles(RAS_PRE_CAS_NS, CLK_PS);
  localparam int CSR_CYC      = max2(ns_to_cycles(CAS_SETUP_NS, CLK_PS),
                                     ns_to_cycles(WE_SETUP_NS, CLK_PS));
  localparam int RASL_CYC     = max2(ns_to_cycles(RAS_LOW_NS, CLK_PS),
                                     ns_to_cycles(CAS_HOLD_NS, CLK_PS));
  localparam int PRE_CYC      = ns_to_cycles(RAS_PRECHARGE_NS, CLK_PS);

  logic pause_done;
  logic tick;
  logic refresh_cmp;
  logic owed_pending;

  rfsh_cycle_timer #(.CYCLES(PAUSE_CYC), .ONE_SHOT(1'b1)) u_pause (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (1'b1),
    .hit   (pause_done)
  );

  rfsh_cycle_timer #(.CYCLES(INTERVAL_CYC), .ONE_SHOT(1'b0)) u_interval (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (ready),
    .hit   (tick)
  );

  rfsh_owed_counter #(.MAX_OWED(MAX_OWED), .URGENT_AT(URGENT_AT), .W(OWED_W)) u_owed (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (tick),
    .dec    (refresh_cmp),
    .owed   (owed_cnt),
    .urgent (urgent)
  );

  assign owed_pending = (owed_cnt != '0);

  rfsh_cbr_seq #(
    .LEAD_CYC (LEAD_CYC),
    .CSR_CYC  (CSR_CYC),
    .RASL_CYC (RASL_CYC),
    .PRE_CYC  (PRE_CYC),
    .INIT_CNT (INIT_CYCLES)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .pause_done   (pause_done),
    .owed_pending (owed_pending),
    .gnt          (rfsh_grant),
    .req          (rfsh_req),
    .own          (bus_own),
    .done         (rfsh_done),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .ready        (ready),
    .refresh_cmp  (refresh_cmp)
  );

  assign we_n = 1'b1;

  // R2: nothing is requested or driven before the pause expires
  a_r2_quiet_in_pause: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_done |-> (!rfsh_req && !bus_own));

  // R3: ready never drops once raised
  a_r3_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R8: strobes are only active while the bus is owned
  a_r8_strobes_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> bus_own);

endmodule

// File: tb/sim_dram_rfsh_sched.sv
`timescale 1ns/1ps
module sim_dram_rfsh_sched;

  // Expected figures from the requirements at a 5 ns clock
  localparam int INT_CYC  = 60;   // 300 ns interval
  localparam int LEAD_EXP = 1;
  localparam int CSR_EXP  = 3;
  localparam int RASL_EXP = 10;
  localparam int PRE_EXP  = 6;
  localparam int INIT_EXP = 8;

  // {interval periods with grant withheld, expected owed, expected urgent}
  localparam int NVEC = 6;
  localparam int VEC [NVEC][3] = '{
    '{1, 1, 0}, '{3, 3, 0}, '{6, 6, 1}, '{7, 7, 1}, '{8, 8, 1}, '{11, 8, 1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt = 1'b1;
  logic req, own, done, ras_n, cas_n, we_n, ready, urgent;
  logic [3:0] owed;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dram_rfsh_sched #(
    .CLK_PS      (5000),
    .PAUSE_NS    (200),
    .INTERVAL_NS (300)
  ) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .rfsh_grant (gnt),
    .rfsh_req   (req),
    .bus_own    (own),
    .rfsh_done  (done),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .ready      (ready),
    .urgent     (urgent),
    .owed_cnt   (owed)
  );

  // Strobe monitor, sampled at falling edges
  int  csr_run = 0, rasl_run = 0, lead_run = 0, pre_run = 0;
  int  last_csr = -1, last_rasl = -1, last_lead = -1, last_pre = -1;
  int  init_dones = 0;
  bit  we_bad = 0, cas_bad = 0, stray_bad = 0, gnt_bad = 0, done_wide = 0, req_in_done = 0;
  logic p_ras = 1'b1, p_cas = 1'b1, p_own = 1'b0, p_gnt = 1'b0, p_done = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      csr_run = 0; rasl_run = 0; lead_run = 0; pre_run = 0;
      p_ras = 1'b1; p_cas = 1'b1; p_own = 1'b0; p_gnt = gnt; p_done = 1'b0;
    end else begin
      if (p_ras && !ras_n) last_csr = csr_run;
      if (!p_ras && ras_n) last_rasl = rasl_run;
      if (p_cas && !cas_n) last_lead = lead_run;
      if (done) begin
        last_pre = pre_run;
        if (!ready) init_dones++;
        if (req || own) req_in_done = 1;
      end
      if (done && p_done) done_wide = 1;
      if (!we_n) we_bad = 1;
      if (!ras_n && cas_n) cas_bad = 1;
      if ((!ras_n || !cas_n) && !own) stray_bad = 1;
      if (own && !p_own && !p_gnt) gnt_bad = 1;
      csr_run  = (!cas_n && ras_n) ? csr_run + 1 : 0;
      rasl_run = !ras_n ? rasl_run + 1 : 0;
      lead_run = (own && ras_n && cas_n) ? lead_run + 1 : 0;
      pre_run  = !ras_n ? 0 : (own ? pre_run + 1 : pre_run);
      p_ras = ras_n; p_cas = cas_n; p_own = own; p_gnt = gnt; p_done = done;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_gnt(input logic v);
    @(posedge clk);
    #1 gnt = v;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", checks + 1, fails + 1);
    $finish;
  end

  initial begin : main
    int n;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(ras_n && cas_n && we_n, "R1 strobes idle", {ras_n, cas_n, we_n}, 7);
    chk(!req && !own && !done, "R1 handshake low", {req, own, done}, 0);
    chk(!ready && !urgent, "R1 ready/urgent low", {ready, urgent}, 0);
    chk(owed == 4'd0, "R1 owed zero", owed, 0);

    @(posedge clk);
    #1 rst_n = 1'b1;

    // R2: pause length before first request
    n = 0;
    while (!req && n < 200) begin
      @(negedge clk);
      n++;
      if (!req && own) chk(1'b0, "R2 own in pause", 1, 0);
    end
    chk(n >= 40 && n <= 45, "R2 first request delay", n, 43);
    chk(!ready, "R2 not ready at first request", ready, 0);

    // R3: init burst then ready
    n = 0;
    while (!ready && n < 1000) begin @(negedge clk); n++; end
    chk(ready, "R3 ready rises", ready, 1);
    chk(init_dones == INIT_EXP, "R3 init cycle count", init_dones, INIT_EXP);
    chk(owed == 4'd0, "R10 owed zero at ready", owed, 0);

    // R4 / R6: strobe shape from the init burst
    chk(last_lead == LEAD_EXP, "R4 RAS-high lead", last_lead, LEAD_EXP);
    chk(last_csr == CSR_EXP, "R4 CAS setup cycles", last_csr, CSR_EXP);
    chk(last_rasl == RASL_EXP, "R6 RAS low cycles", last_rasl, RASL_EXP);
    chk(last_pre == PRE_EXP, "R6 precharge cycles", last_pre, PRE_EXP);

    // R9: withdraw grant while RAS is low
    n = 0;
    while (ras_n && n < 300) begin @(negedge clk); n++; end
    chk(!ras_n, "R9 refresh started", ras_n, 0);
    last_rasl = -1; last_pre = -1;
    set_gnt(1'b0);
    n = 0;
    while (!done && n < 100) begin @(negedge clk); n++; end
    chk(done, "R9 sequence finished", done, 1);
    @(negedge clk);
    chk(last_rasl == RASL_EXP, "R9 RAS low kept", last_rasl, RASL_EXP);
    chk(last_pre == PRE_EXP, "R9 precharge kept", last_pre, PRE_EXP);
    repeat (5) @(negedge clk);
    chk(!own, "R8 no ownership without grant", own, 0);

    // R10 R11 R12: backlog vectors
    for (int i = 0; i < NVEC; i++) begin
      set_gnt(1'b1);
      n = 0;
      while (!(owed == 4'd0 && !req && !own) && n < 3000) begin @(negedge clk); n++; end
      chk(owed == 4'd0, "R10 drained before vector", owed, 0);
      set_gnt(1'b0);
      n = 0;
      while (owed != 4'd1 && n < 200) begin @(negedge clk); n++; end
      repeat (VEC[i][0] * INT_CYC - INT_CYC / 2) @(negedge clk);
      chk(int'(owed) == VEC[i][1], (i == NVEC - 1) ? "R11 saturation" : "R10 tick count",
          owed, VEC[i][1]);
      chk(int'(urgent) == VEC[i][2], "R12 urgent flag", urgent, VEC[i][2]);
      chk(req && !own && ras_n && cas_n, "R8 waiting for grant", {req, own, ras_n, cas_n}, 11);
      set_gnt(1'b1);
      n = 0;
      while (owed != 4'd0 && n < 3000) begin @(negedge clk); n++; end
      chk(owed == 4'd0, "R10 backlog drains", owed, 0);
    end

    // Whole-run monitor flags
    chk(!we_bad, "R7 WE stays high", we_bad, 0);
    chk(!cas_bad, "R5 CAS low under RAS", cas_bad, 0);
    chk(!stray_bad, "R8 strobes only when owned", stray_bad, 0);
    chk(!gnt_bad, "R8 ownership after grant", gnt_bad, 0);
    chk(!done_wide, "R13 done one cycle", done_wide, 0);
    chk(!req_in_done, "R13 bus released at done", req_in_done, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule